// File: doc/BRIEF.md
# Queue-Threshold Congestion Marker

This block is an egress-side stage for a switch pipeline that tags clock-synchronization packets with a measure of the queueing they met. Each packet arrives with three inputs: the queue depth seen when it was enqueued, a path-direction flag, and the congestion mark already in its header. The block compares that depth with a small set of programmable byte thresholds. It counts how many of them the depth exceeds and folds the count into the carried mark. Each hop therefore adds its own share, and the endpoint can use the total to correct its timestamps.

The mark field is split into two equal halves. The upper half belongs to the forward path and the lower half to the reverse path, and only the half named by the direction flag changes. A configuration bit selects one of two encodings. Integer mode adds the count and stops at all-ones. Shift mode pushes a 1 in at the bottom for each crossing, which builds a thermometer code. The block holds no per-packet or per-flow state. Its output is registered one clock after the input and there is no back-pressure.

Top module: `sync_cong_marker`

## Requirements
- R1: The crossing count is the number of thresholds whose value is non-zero and strictly below the queue depth. A depth equal to a threshold does not count, and a zero threshold never counts.
- R2: When `cfg_shift_mode` is 0 (integer mode), the selected subfield becomes its old value plus the crossing count. The result saturates at all-ones and never wraps.
- R3: When `cfg_shift_mode` is 1 (shift mode), each crossing shifts the selected subfield left by one and sets bit 0. Bits that leave the top are dropped, so an all-ones subfield stays all-ones.
- R4: With `in_dir`=0 (forward), only bits [MARK_W-1:MARK_W/2] may change. With `in_dir`=1 (reverse), only bits [MARK_W/2-1:0] may change. The other half is copied unchanged.
- R5: When `cfg_enable` is 0 or `in_is_sync` is 0, `out_mark` equals `in_mark`.
- R6: `out_valid` and `out_mark` are registered. `out_valid` equals `in_valid` of the previous clock. After reset both outputs are 0.
- R7: The block is stateless. Identical inputs and configuration give an identical result whatever packets came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Marking enable |
| cfg_shift_mode | input | 1 | 0 integer encoding, 1 shift encoding |
| cfg_thresholds | input | NUM_THR*DEPTH_W | Thresholds; entry i at bits [i*DEPTH_W +: DEPTH_W], ascending, 0 disables |
| in_valid | input | 1 | Packet descriptor valid |
| in_is_sync | input | 1 | Packet is a synchronization packet |
| in_dir | input | 1 | 0 forward, 1 reverse |
| in_qdepth | input | DEPTH_W | Enqueue-time queue depth in bytes |
| in_mark | input | MARK_W | Mark field carried in the header |
| out_valid | output | 1 | Result valid |
| out_mark | output | MARK_W | Updated mark field |

## Verification
The two functions that can meet on one packet are multi-threshold crossing and subfield saturation. A deep queue crosses several thresholds in the same cycle while the carried subfield is already near all-ones, so the add must clip in integer mode and the shift must drop bits in shift mode. Directed packets set up this case for both encodings and both directions. Random packets with random carried marks hit it often as well. Every output is judged against a bench model that applies the count, the encoding and the subfield choice separately, and it also checks that the other half is left unchanged.

// File: rtl/cm_pkg.sv
package cm_pkg;
   localparam int unsigned CM_MAX_THR = 8;

   typedef enum logic {
      CM_DIR_FWD = 1'b0,
      CM_DIR_REV = 1'b1
   } cm_dir_e;

   // subfield index inside the mark: 1 = upper half (forward), 0 = lower half (reverse)
   localparam int unsigned CM_SUB_REV = 0;
   localparam int unsigned CM_SUB_FWD = 1;
endpackage

// File: rtl/cm_thr_count.sv
module cm_thr_count #(
   parameter int unsigned NUM_THR = 4,
   parameter int unsigned DEPTH_W = 24,
   parameter int unsigned CNT_W   = 3
) (
   input  logic [NUM_THR*DEPTH_W-1:0] thr,
   input  logic [DEPTH_W-1:0]         depth,
   output logic [CNT_W-1:0]           cnt
);
   logic [NUM_THR-1:0] hit;

   generate
      for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
         logic [DEPTH_W-1:0] level;
         assign level  = thr[g*DEPTH_W +: DEPTH_W];
         assign hit[g] = (level != '0) && (depth > level);
      end
   endgenerate

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NUM_THR; i++) begin
         cnt = cnt + CNT_W'(hit[i]);
      end
   end

   always_comb begin
      AST_CNT_RANGE: assert (cnt <= CNT_W'(NUM_THR)); // R1
   end
endmodule

// File: rtl/cm_mark_update.sv
module cm_mark_update #(
   parameter int unsigned SUB_W   = 4,
   parameter int unsigned NUM_THR = 4,
   parameter int unsigned CNT_W   = 3
) (
   input  logic             shift_mode,
   input  logic [SUB_W-1:0] old_sub,
   input  logic [CNT_W-1:0] cnt,
   output logic [SUB_W-1:0] new_sub
);
   localparam int unsigned SUM_W = ((SUB_W > CNT_W) ? SUB_W : CNT_W) + 1;
   localparam logic [SUM_W-1:0] SUB_MAX = SUM_W'({SUB_W{1'b1}});

   logic [SUM_W-1:0] sum_wide;
   logic [SUB_W-1:0] int_val;
   logic [SUB_W-1:0] thermo_val;

   // integer encoding: widened add, then clip
   assign sum_wide = SUM_W'(old_sub) + SUM_W'(cnt);
   assign int_val  = (sum_wide > SUB_MAX) ? {SUB_W{1'b1}} : sum_wide[SUB_W-1:0];

   // shift encoding: one 1 shifted in per crossing
   always_comb begin
      thermo_val = old_sub;
      for (int i = 0; i < NUM_THR; i++) begin
         if (CNT_W'(i) < cnt) begin
            thermo_val = {thermo_val[SUB_W-2:0], 1'b1};
         end
      end
   end

   assign new_sub = shift_mode ? thermo_val : int_val;

   logic [SUB_W-1:0] old_p1, new_p1;
   assign old_p1 = old_sub + 1'b1;
   assign new_p1 = new_sub + 1'b1;

   always_comb begin
      if (!shift_mode) begin
         AST_NO_WRAP: assert (new_sub >= old_sub); // R2
      end
      if (shift_mode && ((old_sub & old_p1) == '0)) begin
         AST_THERMO_KEPT: assert ((new_sub & new_p1) == '0); // R3
      end
      if (cnt == '0) begin
         AST_ZERO_HOLD: assert (new_sub == old_sub); // R1
      end
   end
endmodule

// File: rtl/sync_cong_marker.sv
module sync_cong_marker
   import cm_pkg::*;
#(
   parameter int unsigned NUM_THR = 4,
   parameter int unsigned DEPTH_W = 24,
   parameter int unsigned MARK_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_enable,
   input  logic                       cfg_shift_mode,
   input  logic [NUM_THR*DEPTH_W-1:0] cfg_thresholds,
   input  logic                       in_valid,
   input  logic                       in_is_sync,
   input  logic                       in_dir,
   input  logic [DEPTH_W-1:0]         in_qdepth,
   input  logic [MARK_W-1:0]          in_mark,
   output logic                       out_valid,
   output logic [MARK_W-1:0]          out_mark
);
   localparam int unsigned SUB_W = MARK_W / 2;
   localparam int unsigned CNT_W = $clog2(NUM_THR + 1);

   generate
      if (NUM_THR < 1 || NUM_THR > CM_MAX_THR) begin : g_bad_thr
         $error("NUM_THR must lie in 1..8");
      end
      if ((MARK_W % 2) != 0 || MARK_W < 4) begin : g_bad_mark
         $error("MARK_W must be even and at least 4");
      end
      if (DEPTH_W < 1) begin : g_bad_depth
         $error("DEPTH_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cross_cnt;

   cm_thr_count #(
      .NUM_THR (NUM_THR),
      .DEPTH_W (DEPTH_W),
      .CNT_W   (CNT_W)
   ) u_count (
      .thr   (cfg_thresholds),
      .depth (in_qdepth),
      .cnt   (cross_cnt)
   );

   logic                        apply;
   logic [1:0][SUB_W-1:0]       new_sub;
   logic [MARK_W-1:0]           next_mark;

   assign apply = cfg_enable && in_is_sync;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_sub
         logic             sel;
         logic [CNT_W-1:0] sub_cnt;
         cm_dir_e          own_dir;
         assign own_dir = (g == CM_SUB_FWD) ? CM_DIR_FWD : CM_DIR_REV;
         assign sel     = apply && (cm_dir_e'(in_dir) == own_dir);
         assign sub_cnt = sel ? cross_cnt : '0;

         cm_mark_update #(
            .SUB_W   (SUB_W),
            .NUM_THR (NUM_THR),
            .CNT_W   (CNT_W)
         ) u_update (
            .shift_mode (cfg_shift_mode),
            .old_sub    (in_mark[g*SUB_W +: SUB_W]),
            .cnt        (sub_cnt),
            .new_sub    (new_sub[g])
         );
      end
   endgenerate

   assign next_mark = {new_sub[CM_SUB_FWD], new_sub[CM_SUB_REV]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mark  <= '0;
      end else begin
         out_valid <= in_valid;
         out_mark  <= next_mark;
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R6
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R6
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(cfg_enable && in_is_sync)) |=> (out_mark == $past(in_mark))); // R5
   AST_FWD_KEEPS_REV: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_dir) |=> (out_mark[SUB_W-1:0] == $past(in_mark[SUB_W-1:0]))); // R4
   AST_REV_KEEPS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dir) |=> (out_mark[MARK_W-1:SUB_W] == $past(in_mark[MARK_W-1:SUB_W]))); // R4
endmodule

// File: tb/test_sync_cong_marker.sv
`timescale 1ns/1ps
module test_sync_cong_marker;
   localparam int NUM_THR = 4;
   localparam int DEPTH_W = 24;
   localparam int MARK_W  = 8;
   localparam int SUB_W   = MARK_W / 2;

   logic                       clk = 1'b0;
   logic                       rst_n = 1'b0;
   logic                       cfg_enable = 1'b0;
   logic                       cfg_shift_mode = 1'b0;
   logic [NUM_THR*DEPTH_W-1:0] cfg_thresholds = '0;
   logic                       in_valid = 1'b0;
   logic                       in_is_sync = 1'b0;
   logic                       in_dir = 1'b0;
   logic [DEPTH_W-1:0]         in_qdepth = '0;
   logic [MARK_W-1:0]          in_mark = '0;
   logic                       out_valid;
   logic [MARK_W-1:0]          out_mark;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sync_cong_marker #(.NUM_THR(NUM_THR), .DEPTH_W(DEPTH_W), .MARK_W(MARK_W)) i_sync_cong_marker (
      .clk, .rst_n, .cfg_enable, .cfg_shift_mode, .cfg_thresholds,
      .in_valid, .in_is_sync, .in_dir, .in_qdepth, .in_mark,
      .out_valid, .out_mark
   );

   function automatic int crossings(logic [NUM_THR*DEPTH_W-1:0] thr, logic [DEPTH_W-1:0] d);
      int n = 0;
      for (int i = 0; i < NUM_THR; i++) begin
         logic [DEPTH_W-1:0] t = thr[i*DEPTH_W +: DEPTH_W];
         if (t != 0 && d > t) n++;
      end
      return n;
   endfunction

   function automatic logic [SUB_W-1:0] bump(logic [SUB_W-1:0] v, int n, logic shift);
      int s;
      if (shift) begin
         for (int i = 0; i < n; i++) v = {v[SUB_W-2:0], 1'b1};
         return v;
      end
      s = int'(v) + n;
      if (s > (1 << SUB_W) - 1) s = (1 << SUB_W) - 1;
      return SUB_W'(s);
   endfunction

   function automatic logic [MARK_W-1:0] model(logic en, logic shift, logic sync, logic dir,
                                              logic [DEPTH_W-1:0] d, logic [MARK_W-1:0] m);
      logic [SUB_W-1:0] hi = m[MARK_W-1:SUB_W];
      logic [SUB_W-1:0] lo = m[SUB_W-1:0];
      int n;
      if (!(en && sync)) return m;
      n = crossings(cfg_thresholds, d);
      if (!dir) hi = bump(hi, n, shift);
      else      lo = bump(lo, n, shift);
      return {hi, lo};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_thr(int t0, int t1, int t2, int t3);
      cfg_thresholds = {DEPTH_W'(t3), DEPTH_W'(t2), DEPTH_W'(t1), DEPTH_W'(t0)};
   endtask

   // drive at a falling edge, check at the next falling edge (one register in the path)
   task automatic send(string req, logic v, logic sync, logic dir, int d, logic [MARK_W-1:0] m);
      logic [MARK_W-1:0] exp;
      @(negedge clk);
      in_valid = v; in_is_sync = sync; in_dir = dir; in_qdepth = DEPTH_W'(d); in_mark = m;
      exp = model(cfg_enable, cfg_shift_mode, sync, dir, DEPTH_W'(d), m);
      @(negedge clk);
      check({req, " valid"}, 32'(out_valid), 32'(v));
      if (v) check(req, 32'(out_mark), 32'(exp));
      in_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R6 reset valid", 32'(out_valid), 0);
      check("R6 reset mark", 32'(out_mark), 0);
      rst_n = 1'b1;

      cfg_enable = 1'b1;
      set_thr(100, 200, 400, 800);
      // R1: equality is not a crossing, one above is
      send("R1 equal", 1, 1, 0, 200, 8'h00);
      send("R1 above", 1, 1, 0, 201, 8'h00);
      check("R1 count=2", 32'(out_mark), 32'h20);
      // R1: zero threshold disabled
      set_thr(0, 200, 0, 800);
      send("R1 zero thr", 1, 1, 1, 1000, 8'h00);
      check("R1 two enabled", 32'(out_mark), 32'h02);
      set_thr(100, 200, 400, 800);
      // R2: multiple crossings meet saturation
      send("R2 sat fwd", 1, 1, 0, 900, 8'hD5);
      check("R2 clip", 32'(out_mark), 32'hF5);
      send("R2 add rev", 1, 1, 1, 450, 8'h37);
      check("R2 hop add", 32'(out_mark), 32'h3A);
      // R3: thermometer and full field
      cfg_shift_mode = 1'b1;
      send("R3 shift", 1, 1, 1, 250, 8'h91);
      check("R3 thermo", 32'(out_mark), 32'h97);
      send("R3 full", 1, 1, 0, 900, 8'hF0);
      check("R3 full stays", 32'(out_mark), 32'hF0);
      // R4: direction picks the half
      send("R4 rev only", 1, 1, 1, 150, 8'h50);
      check("R4 fwd kept", 32'(out_mark), 32'h51);
      // R5: disabled or non-sync pass through
      cfg_shift_mode = 1'b0;
      send("R5 non-sync", 1, 0, 0, 900, 8'h12);
      check("R5 pass", 32'(out_mark), 32'h12);
      cfg_enable = 1'b0;
      send("R5 disabled", 1, 1, 1, 900, 8'h34);
      check("R5 pass off", 32'(out_mark), 32'h34);
      cfg_enable = 1'b1;
      // R6: idle slot gives no valid
      send("R6 idle", 0, 1, 0, 900, 8'h00);
      // R7: same packet after different history
      send("R7 first", 1, 1, 0, 500, 8'h21);
      send("R7 other", 1, 1, 1, 900, 8'hEE);
      send("R7 again", 1, 1, 0, 500, 8'h21);
      check("R7 repeat", 32'(out_mark), 32'h51);

      for (int k = 0; k < 400; k++) begin
         if (k % 50 == 0) begin
            int a = 1 + $urandom_range(0, 300);
            int b = a + 1 + $urandom_range(0, 300);
            int c = b + 1 + $urandom_range(0, 300);
            int e = c + 1 + $urandom_range(0, 300);
            if ($urandom_range(0, 3) == 0) a = 0;
            set_thr(a, b, c, e);
            cfg_shift_mode = $urandom_range(0, 1);
            cfg_enable = ($urandom_range(0, 7) != 0);
         end
         send("R1 R2 R3 R4 R5 rand", ($urandom_range(0, 7) != 0), ($urandom_range(0, 5) != 0),
              $urandom_range(0, 1), $urandom_range(0, 1400), MARK_W'($urandom));
      end
      finish_run();
   end
endmodule